// File: doc/BRIEF.md
# GPIO Port Data Register

This block holds the data latch and the direction latch for one general-purpose I/O port and decides what the port shows on a register read. The register is 16 bits wide. Only the top four bits are backed by pins, and the lower twelve are tied to zero. For each pin, the direction bit and a function-select input coming from the pin multiplexer together choose the read source. The source is the stored bit for an output, the synchronized pin level for a GPIO input, or a fixed zero for an input that belongs to another function. The same two signals also decide whether the block drives the pin at all.

Software reaches both latches over a simple synchronous register bus that has an address, a write strobe, write data and a combinational read-data return. The block has two resets. A power-on reset clears both latches. A watchdog reset clears only the input synchronizer and leaves the stored data and direction untouched, so that the port holds its state through the recovery.

Top module: `gpio_port_data_reg`

## Requirements
- R1: At the data address (0), read-data bits 11 to 0 are always 0, and writes to those bits store nothing.
- R2: For a pin whose direction bit is 1, a data read returns the stored bit in that pin's position (pin i is bit 12+i), whatever level the pin input has.
- R3: For a pin with direction 0 and function-select 1 (GPIO), a data read returns the pin input level. The level appears after two rising clock edges of synchronizer latency.
- R4: A data write to an input pin updates the stored bit but leaves the pin undriven (its output enable stays 0). The stored value reads back once the pin is turned to output.
- R5: For a pin with direction 0 and function-select 0 (other function), a data read returns 0 in that pin's bit.
- R6: For a pin with direction 1 and function-select 0, a data read returns the stored bit, and the pin's output enable stays 0.
- R7: While the power-on reset (active low) is asserted, the stored data and direction bits are all 0.
- R8: Asserting the watchdog reset (active low) leaves the stored data and direction bits unchanged.
- R9: A pin's output enable is 1 exactly when its direction bit is 1 and its function-select is 1. The pin output value is always the stored data bit.
- R10: A write followed by a read of the same address in the same cycle returns the old value. The new value is visible from the next cycle on.
- R11: The direction register sits at address 1, with bits 15 to 12 implemented and the other bits reading 0. Any other address reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wdt_rst_n | input | 1 | Watchdog reset, active low; clears only the input synchronizer |
| bus_addr | input | ADDR_W | Register address: 0 selects data, 1 selects direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| pin_in | input | PIN_N | Pin input levels (asynchronous) |
| pin_func_gpio | input | PIN_N | Per-pin function select: 1 means GPIO, 0 means another function |
| pin_out | output | PIN_N | Pin output values |
| pin_oe | output | PIN_N | Pin output enables |

## Verification
The bench targets the four corners of direction and function select on each pin, including a mixed pattern where every pin sits in a different corner. A design that swapped two of the read sources would show the pin level for an output, or the stored bit for a foreign-function input. The bench checks the synchronizer latency edge by edge, so that a design with one flop too few or too many reads the new level on the wrong edge. It also checks the same-cycle write-then-read case, which catches a design that forwards write data into the read path. Finally, it pulses the watchdog reset over non-zero latches, so that a design which wires that reset into the data latch reads back zeros.

// File: rtl/gpio_port_data_reg.sv
module gpio_port_data_reg #(
  parameter int DATA_W    = 16,
  parameter int PIN_N     = 4,
  parameter int ADDR_W    = 2,
  parameter int DATA_ADDR = 0,
  parameter int DIR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              wdt_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_N-1:0]  pin_in,
  input  logic [PIN_N-1:0]  pin_func_gpio,
  output logic [PIN_N-1:0]  pin_out,
  output logic [PIN_N-1:0]  pin_oe
);

  localparam int PIN_LO = DATA_W - PIN_N;

  logic [PIN_N-1:0] data_q, dir_q, sync1_q, sync2_q, port_view;
  logic             sel_data, sel_dir, sync_rst_n, unused_wdata_lo;

  assign sel_data        = bus_addr == ADDR_W'(DATA_ADDR);
  assign sel_dir         = bus_addr == ADDR_W'(DIR_ADDR);
  assign sync_rst_n      = por_rst_n & wdt_rst_n;
  assign unused_wdata_lo = ^bus_wdata[PIN_LO-1:0];

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (bus_we) begin
      if (sel_data) data_q <= bus_wdata[PIN_LO +: PIN_N];
      if (sel_dir)  dir_q  <= bus_wdata[PIN_LO +: PIN_N];
    end
  end

  always_ff @(posedge clk or negedge sync_rst_n) begin
    if (!sync_rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    assign port_view[i] = dir_q[i] ? data_q[i] : (pin_func_gpio[i] & sync2_q[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data)     bus_rdata[PIN_LO +: PIN_N] = port_view;
    else if (sel_dir) bus_rdata[PIN_LO +: PIN_N] = dir_q;
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q & pin_func_gpio;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_rst_n)
    bus_rdata[PIN_LO-1:0] == '0); // R1
  AST_OUT_READ: assert property (@(posedge clk) disable iff (!por_rst_n)
    sel_data |-> ((bus_rdata[PIN_LO +: PIN_N] & dir_q) == (pin_out & dir_q))); // R2
  AST_ALT_IN_ZERO: assert property (@(posedge clk) disable iff (!por_rst_n)
    sel_data |-> ((bus_rdata[PIN_LO +: PIN_N] & ~dir_q & ~pin_func_gpio) == '0)); // R5
  AST_NO_FOREIGN_DRIVE: assert property (@(posedge clk) disable iff (!por_rst_n)
    (pin_oe & ~pin_func_gpio) == '0); // R9
  AST_POR_CLEAR: assert property (@(posedge clk)
    !por_rst_n |-> (pin_out == '0 && dir_q == '0)); // R7
  AST_WDT_HOLD: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!wdt_rst_n && !bus_we) |=> ($stable(pin_out) && $stable(dir_q))); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!por_rst_n)
    (bus_we && sel_data) |=> pin_out == $past(bus_wdata[PIN_LO +: PIN_N])); // R10

endmodule

// File: tb/test_gpio_port_data_reg.sv
`timescale 1ns/1ps
module test_gpio_port_data_reg;
  logic        clk = 0;
  logic        por_rst_n, wdt_rst_n, bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  pin_in, pin_func_gpio, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_data_reg i_gpio_port_data_reg (
    .clk(clk), .por_rst_n(por_rst_n), .wdt_rst_n(wdt_rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_func_gpio(pin_func_gpio), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(0, d); check("R7 data after reset", d, 16'h0);
    rd(1, d); check("R7 dir after reset", d, 16'h0);
    check("R7 oe after reset", {12'h0, pin_oe}, 16'h0);
  endtask

  task automatic t_output_read;
    logic [15:0] d;
    pin_func_gpio = 4'hF;
    wr(1, 16'hFFFF);
    wr(0, 16'hFFFF);
    rd(0, d); check("R1 reserved bits zero", d, 16'hF000);
    wr(0, 16'hA000); pin_in = 4'h5;
    repeat (3) @(negedge clk);
    rd(0, d); check("R2 output read ignores pin", d, 16'hA000);
    check("R9 oe all gpio outputs", {12'h0, pin_oe}, 16'h000F);
    check("R9 pin_out follows latch", {12'h0, pin_out}, 16'h000A);
  endtask

  task automatic t_input;
    logic [15:0] d;
    wr(1, 16'h0000); pin_func_gpio = 4'hF;
    pin_in = 4'h0; repeat (3) @(negedge clk);
    bus_addr = 0; pin_in = 4'h6;
    #1 check("R3 no change before edges", bus_rdata, 16'h0000);
    @(negedge clk); #1 check("R3 unchanged after one edge", bus_rdata, 16'h0000);
    @(negedge clk); #1 check("R3 visible after two edges", bus_rdata, 16'h6000);
    wr(0, 16'h5000);
    check("R4 input write not driven", {12'h0, pin_oe}, 16'h0);
    rd(0, d); check("R4 input still reads pin", d, 16'h6000);
    wr(1, 16'hF000);
    rd(0, d); check("R4 stored value after turn to output", d, 16'h5000);
  endtask

  task automatic t_alt;
    logic [15:0] d;
    pin_func_gpio = 4'h0; pin_in = 4'hF; wr(1, 16'h0000);
    repeat (3) @(negedge clk);
    rd(0, d); check("R5 foreign input reads zero", d, 16'h0000);
    wr(0, 16'h9000); wr(1, 16'hF000);
    rd(0, d); check("R6 foreign output reads latch", d, 16'h9000);
    check("R6 foreign output not driven", {12'h0, pin_oe}, 16'h0);
  endtask

  task automatic t_mixed;
    logic [15:0] d;
    // pin3: out/gpio, pin2: out/foreign, pin1: in/gpio, pin0: in/foreign
    pin_func_gpio = 4'b1010; pin_in = 4'b0111;
    wr(1, 16'hC000); wr(0, 16'h4000);
    repeat (3) @(negedge clk);
    rd(0, d); check("R2 R3 R5 R6 mixed read", d, 16'h6000);
    check("R9 mixed oe", {12'h0, pin_oe}, 16'h0008);
  endtask

  task automatic t_same_cycle;
    wr(1, 16'hF000); wr(0, 16'h3000);
    @(negedge clk); bus_addr = 0; bus_wdata = 16'hC000; bus_we = 1;
    #1 check("R10 same-cycle read old", bus_rdata, 16'h3000);
    @(negedge clk); bus_we = 0;
    #1 check("R10 next-cycle read new", bus_rdata, 16'hC000);
  endtask

  task automatic t_wdt;
    logic [15:0] d;
    wr(1, 16'h5000); wr(0, 16'hB000);
    @(negedge clk); wdt_rst_n = 0;
    repeat (3) @(negedge clk); wdt_rst_n = 1;
    rd(1, d); check("R8 dir kept through watchdog", d, 16'h5000);
    wr(1, 16'hF000);
    rd(0, d); check("R8 data kept through watchdog", d, 16'hB000);
  endtask

  task automatic t_por;
    logic [15:0] d;
    @(negedge clk); por_rst_n = 0;
    repeat (2) @(negedge clk); por_rst_n = 1;
    rd(0, d); check("R7 data cleared by power-on", d, 16'h0);
    rd(1, d); check("R7 dir cleared by power-on", d, 16'h0);
  endtask

  task automatic t_dir_reg;
    logic [15:0] d;
    wr(1, 16'hFFFF);
    rd(1, d); check("R11 dir implemented bits", d, 16'hF000);
    wr(1, 16'h2ABC);
    rd(1, d); check("R11 dir pattern", d, 16'h2000);
    wr(2, 16'hFFFF);
    rd(2, d); check("R11 unmapped address zero", d, 16'h0);
    rd(0, d); check("R1 R11 unmapped write leaves data", d & 16'h2000, 16'h0);
  endtask

  initial begin
    por_rst_n = 0; wdt_rst_n = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    pin_in = 0; pin_func_gpio = 4'hF;
    repeat (3) @(negedge clk); por_rst_n = 1;
    t_reset; t_output_read; t_input; t_alt; t_mixed;
    t_same_cycle; t_wdt; t_por; t_dir_reg;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule